// File: doc/BRIEF.md
# UART Channel Interrupt Arbiter

This block gathers every interrupt cause of one UART channel, records each one as pending until its own service action happens, and reports a single cause at a time through a six-bit status code together with an active-high interrupt line. Each cause has a different service action. Depending on the cause, this is a read of a given register, a data read, a write of transmit data, the receive count dropping, the next received character, or an Xon strobe.

A receive timeout timer also sits inside the block. It counts bit-time ticks while the receive FIFO holds data. It fires after four character times plus twelve bit times with no new character and no data read. Two arbitration states control reporting. In `ST_IDLE` the status follows the highest-priority enabled pending cause. On the first clock with any enabled pending cause, the transition *latch* moves to `ST_SHOW` and stores that cause. In `ST_SHOW` the stored cause is reported for as long as it stays pending, even if a higher-priority cause arrives. When the stored cause is serviced, the *advance* transition stores the new highest cause and stays in `ST_SHOW`. If nothing is left, the *release* transition returns to `ST_IDLE`.

The serial shifter, the FIFOs, the baud generator and the character comparators are outside the block. The block only sees their levels and strobes.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Source indices 0..6 are, from highest priority to lowest: line status, receive data, receive timeout, transmit ready, modem status, Xoff/special, flow-pin change. Their codes on stat_o are 000110, 000100, 001100, 000010, 000000, 010000 and 100000. When nothing enabled is pending, stat_o reads 000001.
- R2: Receive data is pending while rx_lvl_i >= rx_trig_i in FIFO mode (fifo_mode_i=1), and while rx_lvl_i != 0 otherwise. It drops as soon as that condition stops holding.
- R3: With B = chr_bits_i, the timeout becomes pending on the (4*B+12)-th bit tick counted since the last restart, and not before. A restart happens on rx_chr_i, on rhr_rd_i, or while rx_lvl_i is 0. The rhr_rd_i strobe clears the timeout.
- R4: Transmit ready is set when the transmit FIFO level goes from above tx_trig_i to at or below it, or goes to zero. thr_wr_i clears it. stat_rd_i clears it only in a cycle where code 000010 is being reported.
- R5: A strobe on any bit of ls_err_i sets line status. lsr_rd_i clears it.
- R6: Any bit of ms_chg_i sets modem status, and fc_edge_i sets flow-pin change. msr_rd_i clears both.
- R7: xoff_i sets the Xoff flag and xon_i clears it. spc_i sets the special flag and a later rx_chr_i clears it. stat_rd_i clears both flags in a cycle where 010000 is being reported.
- R8: A reported cause stays on stat_o while it remains pending, even when a cause of higher priority becomes pending.
- R9: Bit i of en_i gates source i. A disabled source is still recorded, but it affects neither irq_o nor stat_o until it is enabled.
- R10: irq_o is 1 exactly when some enabled source is pending, which is exactly when stat_o[0] is 0.
- R11: When a set and a clear of the same source happen in the same cycle, the set wins.
- R12: After reset nothing is pending: irq_o is 0 and stat_o is 000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 7 | Per-source enable, bit i for source i |
| fifo_mode_i | input | 1 | 1 selects trigger-level receive interrupt |
| rx_lvl_i | input | LVL_W | Receive FIFO fill count |
| rx_trig_i | input | LVL_W | Receive trigger level |
| tx_lvl_i | input | LVL_W | Transmit FIFO fill count |
| tx_trig_i | input | LVL_W | Transmit trigger level |
| ls_err_i | input | 4 | Overrun, parity, framing and break event strobes |
| ms_chg_i | input | 4 | Modem line change strobes |
| xoff_i | input | 1 | Xoff character detected |
| xon_i | input | 1 | Xon character detected |
| spc_i | input | 1 | Special character detected |
| rx_chr_i | input | 1 | A character entered the receive FIFO |
| fc_edge_i | input | 1 | Flow-control pin low-to-high edge |
| bit_tick_i | input | 1 | One pulse per bit time |
| chr_bits_i | input | CHB_W | Bit times per character |
| stat_rd_i | input | 1 | Status code read strobe |
| lsr_rd_i | input | 1 | Line status register read strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| rhr_rd_i | input | 1 | Receive holding register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| irq_o | output | 1 | Interrupt request, active high |
| stat_o | output | 6 | Code of the reported source |

## Verification
A wrong pending flag shows up on stat_o and irq_o in the cycle after the strobe that should have set or cleared it. The tests therefore pulse one cause and service it, and check the code after every such edge. A wrong arbitration state would either let a higher cause replace a reported one early, or hold a serviced code stale. The hold and service sequences expose both of these within one cycle. A timeout counter that is off by even one tick is caught, because the bench checks the code after exactly 4*B+11 and 4*B+12 ticks for several character lengths.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC  = 7;
    localparam int IDX_W = $clog2(NSRC);

    localparam int SRC_LS  = 0;
    localparam int SRC_RXD = 1;
    localparam int SRC_TMO = 2;
    localparam int SRC_TX  = 3;
    localparam int SRC_MS  = 4;
    localparam int SRC_XS  = 5;
    localparam int SRC_FC  = 6;

    localparam logic [5:0] CODE_NONE = 6'b000001;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } arb_st_e;

    function automatic logic [5:0] code_of(input logic [IDX_W-1:0] idx);
        logic [5:0] c;
        case (idx)
            3'd0:    c = 6'b000110;
            3'd1:    c = 6'b000100;
            3'd2:    c = 6'b001100;
            3'd3:    c = 6'b000010;
            3'd4:    c = 6'b000000;
            3'd5:    c = 6'b010000;
            3'd6:    c = 6'b100000;
            default: c = CODE_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_rxtmo.sv
module uart_irq_rxtmo #(
    parameter int LVL_W = 5,
    parameter int CHB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_lvl_i,
    input  logic             rx_chr_i,
    input  logic             rhr_rd_i,
    input  logic             tick_i,
    input  logic [CHB_W-1:0] chr_bits_i,
    output logic             tmo_o
);
    localparam int TERM_MAX = 4 * ((1 << CHB_W) - 1) + 12;
    localparam int CNT_W    = $clog2(TERM_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;
    logic             restart;

    assign term    = CNT_W'({chr_bits_i, 2'b00}) + CNT_W'(12);
    assign restart = rhr_rd_i | rx_chr_i | (rx_lvl_i == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q < term)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_o <= 1'b0;
        end else if (rhr_rd_i) begin
            tmo_o <= 1'b0;
        end else if (!restart && tick_i && (cnt_q == term - CNT_W'(1))) begin
            tmo_o <= 1'b1;
        end
    end

    // R3
    tmo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rhr_rd_i |=> !tmo_o);

    // R3
    tmo_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_o) |-> $past(tick_i));

endmodule

// File: rtl/uart_irq_srcs.sv
module uart_irq_srcs
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode_i,
    input  logic [LVL_W-1:0] rx_lvl_i,
    input  logic [LVL_W-1:0] rx_trig_i,
    input  logic [LVL_W-1:0] tx_lvl_i,
    input  logic [LVL_W-1:0] tx_trig_i,
    input  logic [3:0]       ls_err_i,
    input  logic [3:0]       ms_chg_i,
    input  logic             xoff_i,
    input  logic             xon_i,
    input  logic             spc_i,
    input  logic             rx_chr_i,
    input  logic             fc_edge_i,
    input  logic             tmo_i,
    input  logic             stat_rd_i,
    input  logic             lsr_rd_i,
    input  logic             msr_rd_i,
    input  logic             thr_wr_i,
    input  logic             rep_vld_i,
    input  logic [IDX_W-1:0] rep_idx_i,
    output logic [NSRC-1:0]  pend_o
);
    logic ls_q, tx_q, ms_q, xoff_q, spc_q, fc_q, tx_prev_q;
    logic rxd, tx_cond, tx_set, rd_tx, rd_xs;

    assign rxd     = fifo_mode_i ? (rx_lvl_i >= rx_trig_i) : (rx_lvl_i != '0);
    assign tx_cond = (tx_lvl_i <= tx_trig_i) || (tx_lvl_i == '0);
    assign tx_set  = tx_cond && !tx_prev_q;
    assign rd_tx   = stat_rd_i && rep_vld_i && (rep_idx_i == IDX_W'(SRC_TX));
    assign rd_xs   = stat_rd_i && rep_vld_i && (rep_idx_i == IDX_W'(SRC_XS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ls_q      <= 1'b0;
            tx_q      <= 1'b0;
            ms_q      <= 1'b0;
            xoff_q    <= 1'b0;
            spc_q     <= 1'b0;
            fc_q      <= 1'b0;
            tx_prev_q <= 1'b1;
        end else begin
            ls_q      <= (|ls_err_i) | (ls_q & ~lsr_rd_i);
            tx_q      <= tx_set | (tx_q & ~(thr_wr_i | rd_tx));
            ms_q      <= (|ms_chg_i) | (ms_q & ~msr_rd_i);
            xoff_q    <= xoff_i | (xoff_q & ~(xon_i | rd_xs));
            spc_q     <= spc_i | (spc_q & ~(rx_chr_i | rd_xs));
            fc_q      <= fc_edge_i | (fc_q & ~msr_rd_i);
            tx_prev_q <= tx_cond;
        end
    end

    assign pend_o = {fc_q, xoff_q | spc_q, ms_q, tx_q, tmo_i, rxd, ls_q};

    // R5
    ls_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd_i && (ls_err_i == 4'b0)) |=> !pend_o[SRC_LS]);

    // R6
    fc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd_i && !fc_edge_i) |=> !pend_o[SRC_FC]);

    // R4
    tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr_i && !tx_set) |=> !pend_o[SRC_TX]);

    // R11
    ls_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ls_err_i) |=> pend_o[SRC_LS]);

endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  masked_i,
    output logic [5:0]       stat_o,
    output logic             rep_vld_o,
    output logic [IDX_W-1:0] rep_idx_o
);
    arb_st_e          st_q, st_d;
    logic [IDX_W-1:0] cur_q, cur_d, hi;
    logic             any;

    always_comb begin
        hi = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (masked_i[i]) hi = IDX_W'(i);
        end
    end

    assign any = |masked_i;

    always_comb begin
        st_d  = st_q;
        cur_d = cur_q;
        unique case (st_q)
            ST_IDLE: begin
                if (any) begin
                    st_d  = ST_SHOW;
                    cur_d = hi;
                end
            end
            ST_SHOW: begin
                if (!masked_i[cur_q]) begin
                    if (any) cur_d = hi;
                    else     st_d  = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cur_q <= '0;
        end else begin
            st_q  <= st_d;
            cur_q <= cur_d;
        end
    end

    always_comb begin
        rep_vld_o = any;
        if (st_q == ST_SHOW && masked_i[cur_q]) begin
            rep_idx_o = cur_q;
        end else begin
            rep_idx_o = hi;
        end
        stat_o = any ? code_of(rep_idx_o) : CODE_NONE;
    end

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHOW && masked_i[cur_q]) |=>
        (!masked_i[$past(cur_q)] || stat_o == $past(stat_o)));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter int CHB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [6:0]       en_i,
    input  logic             fifo_mode_i,
    input  logic [LVL_W-1:0] rx_lvl_i,
    input  logic [LVL_W-1:0] rx_trig_i,
    input  logic [LVL_W-1:0] tx_lvl_i,
    input  logic [LVL_W-1:0] tx_trig_i,
    input  logic [3:0]       ls_err_i,
    input  logic [3:0]       ms_chg_i,
    input  logic             xoff_i,
    input  logic             xon_i,
    input  logic             spc_i,
    input  logic             rx_chr_i,
    input  logic             fc_edge_i,
    input  logic             bit_tick_i,
    input  logic [CHB_W-1:0] chr_bits_i,
    input  logic             stat_rd_i,
    input  logic             lsr_rd_i,
    input  logic             msr_rd_i,
    input  logic             rhr_rd_i,
    input  logic             thr_wr_i,
    output logic             irq_o,
    output logic [5:0]       stat_o
);
    logic                 tmo;
    logic [NSRC-1:0]      pend, masked;
    logic                 rep_vld;
    logic [IDX_W-1:0]     rep_idx;

    uart_irq_rxtmo #(.LVL_W(LVL_W), .CHB_W(CHB_W)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_lvl_i   (rx_lvl_i),
        .rx_chr_i   (rx_chr_i),
        .rhr_rd_i   (rhr_rd_i),
        .tick_i     (bit_tick_i),
        .chr_bits_i (chr_bits_i),
        .tmo_o      (tmo)
    );

    uart_irq_srcs #(.LVL_W(LVL_W)) u_srcs (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_mode_i (fifo_mode_i),
        .rx_lvl_i    (rx_lvl_i),
        .rx_trig_i   (rx_trig_i),
        .tx_lvl_i    (tx_lvl_i),
        .tx_trig_i   (tx_trig_i),
        .ls_err_i    (ls_err_i),
        .ms_chg_i    (ms_chg_i),
        .xoff_i      (xoff_i),
        .xon_i       (xon_i),
        .spc_i       (spc_i),
        .rx_chr_i    (rx_chr_i),
        .fc_edge_i   (fc_edge_i),
        .tmo_i       (tmo),
        .stat_rd_i   (stat_rd_i),
        .lsr_rd_i    (lsr_rd_i),
        .msr_rd_i    (msr_rd_i),
        .thr_wr_i    (thr_wr_i),
        .rep_vld_i   (rep_vld),
        .rep_idx_i   (rep_idx),
        .pend_o      (pend)
    );

    assign masked = pend & en_i;
    assign irq_o  = |masked;

    uart_irq_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .masked_i  (masked),
        .stat_o    (stat_o),
        .rep_vld_o (rep_vld),
        .rep_idx_o (rep_idx)
    );

    // R10
    irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == !stat_o[0]);

    // R9
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == 7'b0) |-> (!irq_o && stat_o == CODE_NONE));

endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int LW    = 5;
    localparam int CW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [6:0]    en = '0;
    logic          fifo_mode = 1'b1;
    logic [LW-1:0] rx_lvl = '0, rx_trig = '0, tx_lvl = '0, tx_trig = '0;
    logic [3:0]    ls_err = '0, ms_chg = '0;
    logic          xoff = 0, xon = 0, spc = 0, rx_chr = 0, fc_edge = 0, tick = 0;
    logic [CW-1:0] chr_bits = 4'd1;
    logic          stat_rd = 0, lsr_rd = 0, msr_rd = 0, rhr_rd = 0, thr_wr = 0;
    logic          irq;
    logic [5:0]    stat;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    uart_irq_ctrl #(.LVL_W(LW), .CHB_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .fifo_mode_i(fifo_mode),
        .rx_lvl_i(rx_lvl), .rx_trig_i(rx_trig), .tx_lvl_i(tx_lvl), .tx_trig_i(tx_trig),
        .ls_err_i(ls_err), .ms_chg_i(ms_chg), .xoff_i(xoff), .xon_i(xon), .spc_i(spc),
        .rx_chr_i(rx_chr), .fc_edge_i(fc_edge), .bit_tick_i(tick), .chr_bits_i(chr_bits),
        .stat_rd_i(stat_rd), .lsr_rd_i(lsr_rd), .msr_rd_i(msr_rd), .rhr_rd_i(rhr_rd),
        .thr_wr_i(thr_wr), .irq_o(irq), .stat_o(stat)
    );

    function automatic logic [5:0] exp_code(input int idx);
        logic [5:0] t [7] = '{6'd6, 6'd4, 6'd12, 6'd2, 6'd0, 6'd16, 6'd32};
        if (idx < 0) return 6'd1;
        return t[idx];
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [5:0] es, input logic ei);
        total++;
        if (stat !== es || irq !== ei) begin
            bad++;
            $display("FAIL %s stat=%b irq=%b expected stat=%b irq=%b", req, stat, irq, es, ei);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        en = '0;
        cyc();
        cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1; cyc(); tick = 0; cyc();
        end
    endtask

    task automatic tx_fire();
        tx_lvl = 5'd5; cyc();
        tx_lvl = 5'd0; cyc();
    endtask

    initial begin
        #(CLK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tx_trig = 5'd2;
        rx_trig = 5'd2;
        do_reset();
        // R12 reset state
        chk("R12", 6'd1, 1'b0);

        // make all seven sources pending while disabled
        rx_lvl = 5'd3; chr_bits = 4'd1;
        rhr_rd = 1; cyc(); rhr_rd = 0;
        tick_n(16);
        tx_fire();
        ls_err = 4'b0100; ms_chg = 4'b0001; xoff = 1; fc_edge = 1; cyc();
        ls_err = 0; ms_chg = 0; xoff = 0; fc_edge = 0; cyc();
        // R9 disabled sources invisible
        chk("R9", 6'd1, 1'b0);

        // R1 R9 R10 sweep every enable mask
        for (int m = 1; m < 128; m++) begin
            int lo;
            en = '0; cyc();
            en = 7'(m); cyc();
            lo = -1;
            for (int b = 6; b >= 0; b--) if (m[b]) lo = b;
            chk("R1", exp_code(lo), 1'b1);
        end

        // service in priority order
        en = 7'h7f; cyc();
        chk("R1", 6'd6, 1'b1);
        lsr_rd = 1; cyc(); lsr_rd = 0;
        chk("R5", 6'd4, 1'b1);
        rx_lvl = 5'd1; cyc();
        chk("R2", 6'd12, 1'b1);
        rhr_rd = 1; cyc(); rhr_rd = 0;
        chk("R3", 6'd2, 1'b1);
        stat_rd = 1; cyc(); stat_rd = 0;
        chk("R4", 6'd0, 1'b1);
        msr_rd = 1; cyc(); msr_rd = 0;
        chk("R6", 6'd16, 1'b1);
        stat_rd = 1; cyc(); stat_rd = 0;
        chk("R7", 6'd1, 1'b0);

        // R8 hold against higher priority
        rx_lvl = 0; cyc();
        tx_fire();
        chk("R4", 6'd2, 1'b1);
        ls_err = 4'b0001; cyc(); ls_err = 0; cyc();
        chk("R8", 6'd2, 1'b1);
        stat_rd = 1; cyc(); stat_rd = 0;
        chk("R8", 6'd6, 1'b1);
        lsr_rd = 1; cyc(); lsr_rd = 0;
        chk("R5", 6'd1, 1'b0);

        // R4 status read does not clear tx when not reported
        tx_lvl = 5'd5; cyc();
        tx_lvl = 5'd0; ls_err = 4'b1000; cyc(); ls_err = 0;
        chk("R4", 6'd6, 1'b1);
        stat_rd = 1; cyc(); stat_rd = 0;
        lsr_rd = 1; cyc(); lsr_rd = 0;
        chk("R4", 6'd2, 1'b1);
        thr_wr = 1; cyc(); thr_wr = 0;
        chk("R4", 6'd1, 1'b0);

        // R11 set wins over same-cycle clear
        ls_err = 4'b0010; lsr_rd = 1; cyc(); ls_err = 0; lsr_rd = 0;
        chk("R11", 6'd6, 1'b1);
        lsr_rd = 1; cyc(); lsr_rd = 0;
        chk("R5", 6'd1, 1'b0);

        // R7 Xoff / Xon and special / next char
        xoff = 1; cyc(); xoff = 0;
        chk("R7", 6'd16, 1'b1);
        xon = 1; cyc(); xon = 0;
        chk("R7", 6'd1, 1'b0);
        spc = 1; rx_chr = 1; cyc(); spc = 0; rx_chr = 0;
        chk("R7", 6'd16, 1'b1);
        rx_chr = 1; cyc(); rx_chr = 0;
        chk("R7", 6'd1, 1'b0);

        // R6 flow pin and modem status
        fc_edge = 1; cyc(); fc_edge = 0;
        chk("R6", 6'd32, 1'b1);
        msr_rd = 1; cyc(); msr_rd = 0;
        chk("R6", 6'd1, 1'b0);

        // R9 disabled modem change recorded then shown
        en = 7'h00; ms_chg = 4'b1000; cyc(); ms_chg = 0; cyc();
        chk("R9", 6'd1, 1'b0);
        en = 7'h10; cyc();
        chk("R9", 6'd0, 1'b1);
        msr_rd = 1; cyc(); msr_rd = 0;
        chk("R6", 6'd1, 1'b0);

        // R2 trigger-level sweep and non-FIFO mode
        en = 7'h02; fifo_mode = 1;
        for (int t = 1; t <= 8; t++) begin
            for (int l = 0; l <= 16; l++) begin
                rx_trig = 5'(t); rx_lvl = 5'(l); cyc();
                chk("R2", (l >= t) ? 6'd4 : 6'd1, l >= t);
            end
        end
        fifo_mode = 0;
        for (int l = 0; l <= 3; l++) begin
            rx_lvl = 5'(l); cyc();
            chk("R2", (l != 0) ? 6'd4 : 6'd1, l != 0);
        end

        // R3 timeout length sweep and restart
        fifo_mode = 1; rx_trig = 5'd8; rx_lvl = 5'd1; en = 7'h04;
        for (int b = 1; b <= 10; b++) begin
            int term;
            term = 4 * b + 12;
            chr_bits = 4'(b);
            rhr_rd = 1; cyc(); rhr_rd = 0;
            tick_n(term - 1);
            chk("R3", 6'd1, 1'b0);
            tick_n(1);
            chk("R3", 6'd12, 1'b1);
            rhr_rd = 1; cyc(); rhr_rd = 0;
            chk("R3", 6'd1, 1'b0);
            tick_n(term - 2);
            rx_chr = 1; cyc(); rx_chr = 0;
            tick_n(term - 1);
            chk("R3", 6'd1, 1'b0);
            tick_n(1);
            chk("R3", 6'd12, 1'b1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule